// File: doc/BRIEF.md
# Seven-slot pixel serializer with selectable colour packing

The block accepts one parallel pixel for every pixel period and sends it out as a serial stream. The pixel has up to ten bits each of red, green and blue, plus horizontal sync, vertical sync and data enable. The block runs on a fast clock at seven times the pixel rate. That fast clock is phase-locked to the pixel rate and comes from outside the block. Each pixel period is split into seven bit slots. In every slot the block drives one bit on each of up to five data lanes and one bit on a clock lane.

The transmitter picks one of five packings with a static mode input: a three-lane 18-bit packing, two four-lane 24-bit packings and two five-lane 30-bit packings. The two 24-bit packings differ in where the least significant colour bits go. So do the two 30-bit packings. The analog drivers, the clock generation, deskew and the receiver all sit outside this block.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst` is high, every data lane and the clock lane output 0.
- R2: Once reset ends, the outputs repeat a period of seven fast cycles, slots 0 to 6. `lane_clk` reads 1,1,0,0,0,1,1 over slots 0 to 6. Slot 0 of the first period appears in the cycle after the first rising edge at which `rst` is low.
- R3: The colour and sync inputs are captured on the rising edge that starts slot 0. Changing them during slots 1 to 6 does not alter the period being sent.
- R4: Mode 2 is VESA 24-bit. Slots 0..6 carry:
  - lane 0: G0 R5 R4 R3 R2 R1 R0
  - lane 1: B1 B0 G5 G4 G3 G2 G1
  - lane 2: DE VS HS B5 B4 B3 B2
  - lane 3: 0 B7 B6 G7 G6 R7 R6
  - lane 4: 0 in every slot
- R5: Mode 1 is JEIDA 24-bit. Slots 0..6 carry:
  - lane 0: G2 R7 R6 R5 R4 R3 R2
  - lane 1: B3 B2 G7 G6 G5 G4 G3
  - lane 2: DE VS HS B7 B6 B5 B4
  - lane 3: 0 B1 B0 G1 G0 R1 R0
  - lane 4: 0 in every slot
- R6: Mode 4 is VESA 30-bit. Lanes 0 to 3 match mode 2. Lane 4 carries 0 B9 B8 G9 G8 R9 R8 in slots 0..6.
- R7: Mode 3 is JEIDA 30-bit. Slots 0..6 carry:
  - lane 0: G4 R9 R8 R7 R6 R5 R4
  - lane 1: B5 B4 G9 G8 G7 G6 G5
  - lane 2: DE VS HS B9 B8 B7 B6
  - lane 3: 0 B3 B2 G3 G2 R3 R2
  - lane 4: 0 B1 B0 G1 G0 R1 R0
- R8: Mode 0 is 18-bit. Lanes 0 to 2 follow the mode 2 layout for colour bits 0 to 5, and colour bits 6 to 9 are ignored. Lanes 3 and 4 stay 0.
- R9: The control slots work as follows:
  - horizontal sync goes in lane 2 slot 2
  - vertical sync goes in lane 2 slot 1
  - data enable goes in lane 2 slot 0
  - the fourth control bit is a constant 0 in slot 0 of lanes 3 and 4
- R10: `mode` is sampled only while `rst` is high. Changing it after reset leaves the packing unchanged.
- R11: Mode codes 5, 6 and 7 drive every data lane to 0, while the clock lane keeps its pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven cycles per pixel |
| rst | input | 1 | Synchronous active-high reset; also latches `mode` |
| mode | input | 3 | Packing select (0: 18-bit, 1: JEIDA 24, 2: VESA 24, 3: JEIDA 30, 4: VESA 30) |
| red | input | 10 | Red component |
| green | input | 10 | Green component |
| blue | input | 10 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| lane_data | output | 5 | Serial data lanes, bit n is lane n |
| lane_clk | output | 1 | Serial clock lane |

## Verification
Two things happen on the same edge: the block loads the next pixel, and slot 6 of the previous pixel finishes leaving the shift registers. The bench streams pixels back to back, with a new random value on every boundary, so every load hits that edge. It checks each of the seven slots on every lane against a table it builds itself. Some periods also change the inputs, or the mode, partway through the period. A wrong period would then show up as leaked bits in the serial stream.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

    localparam int COLOR_W   = 10;
    localparam int NUM_LANES = 5;
    localparam int NUM_SLOTS = 7;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int MODE_W    = 3;
    localparam int BASE_W    = 4;

    // clock lane value per slot, bit s = slot s
    localparam logic [NUM_SLOTS-1:0] CLK_LANE_WORD = 7'b1100011;

    typedef enum logic [MODE_W-1:0] {
        PACK_18  = 3'd0,
        PACK_J24 = 3'd1,
        PACK_V24 = 3'd2,
        PACK_J30 = 3'd3,
        PACK_V30 = 3'd4
    } pack_mode_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
        logic               hsync;
        logic               vsync;
        logic               de;
    } pixel_t;

    // Every packing is three "wide" lanes sharing one colour offset
    // and up to two "narrow" lanes, each holding two bits per colour.
    typedef struct packed {
        logic [NUM_LANES-1:0]         lane_en;
        logic [BASE_W-1:0]            wide_base;
        logic [1:0][BASE_W-1:0]       narrow_base;
    } layout_t;

    function automatic layout_t layout_of(logic [MODE_W-1:0] code);
        layout_t lay;
        lay = '0;
        case (code)
            PACK_18: begin
                lay.lane_en   = 5'b00111;
                lay.wide_base = 4'd0;
            end
            PACK_J24: begin
                lay.lane_en        = 5'b01111;
                lay.wide_base      = 4'd2;
                lay.narrow_base[0] = 4'd0;
            end
            PACK_V24: begin
                lay.lane_en        = 5'b01111;
                lay.wide_base      = 4'd0;
                lay.narrow_base[0] = 4'd6;
            end
            PACK_J30: begin
                lay.lane_en        = 5'b11111;
                lay.wide_base      = 4'd4;
                lay.narrow_base[0] = 4'd2;
                lay.narrow_base[1] = 4'd0;
            end
            PACK_V30: begin
                lay.lane_en        = 5'b11111;
                lay.wide_base      = 4'd0;
                lay.narrow_base[0] = 4'd6;
                lay.narrow_base[1] = 4'd8;
            end
            default: lay = '0;
        endcase
        return lay;
    endfunction

    // wide lane word; which selects lane 0, 1 or 2, k is the colour offset
    function automatic logic [NUM_SLOTS-1:0] wide_word(pixel_t p, logic [1:0] which,
                                                       logic [BASE_W-1:0] k);
        logic [NUM_SLOTS-1:0] w;
        logic [BASE_W-1:0]    idx;
        w = '0;
        case (which)
            2'd0: begin
                w[0] = p.green[k];
                for (int i = 1; i < NUM_SLOTS; i++) begin
                    idx  = k + BASE_W'(6 - i);
                    w[i] = p.red[idx];
                end
            end
            2'd1: begin
                idx  = k + 4'd1;
                w[0] = p.blue[idx];
                w[1] = p.blue[k];
                for (int i = 2; i < NUM_SLOTS; i++) begin
                    idx  = k + BASE_W'(7 - i);
                    w[i] = p.green[idx];
                end
            end
            default: begin
                w[0] = p.de;
                w[1] = p.vsync;
                w[2] = p.hsync;
                for (int i = 3; i < NUM_SLOTS; i++) begin
                    idx  = k + BASE_W'(8 - i);
                    w[i] = p.blue[idx];
                end
            end
        endcase
        return w;
    endfunction

    // narrow lane word: fourth control bit (0), then pairs of blue, green, red
    function automatic logic [NUM_SLOTS-1:0] narrow_word(pixel_t p, logic [BASE_W-1:0] j);
        logic [NUM_SLOTS-1:0] w;
        logic [BASE_W-1:0]    hi;
        hi   = j + 4'd1;
        w[0] = 1'b0;
        w[1] = p.blue[hi];
        w[2] = p.blue[j];
        w[3] = p.green[hi];
        w[4] = p.green[j];
        w[5] = p.red[hi];
        w[6] = p.red[j];
        return w;
    endfunction

endpackage

// File: rtl/lvds_slot_counter.sv
module lvds_slot_counter
    import lvds_ser_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int CW   = $clog2(SLOTS),
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] slot,
    output logic          load
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= LAST;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // load happens on the edge that ends the last slot
    assign load = !rst && (slot == LAST);
endmodule

// File: rtl/lvds_slot_mapper.sv
module lvds_slot_mapper
    import lvds_ser_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int SLOTS = NUM_SLOTS,
    localparam int WIDE_LANES = 3
) (
    input  logic [MODE_W-1:0]             mode_code,
    input  pixel_t                        pix,
    output logic [LANES-1:0][SLOTS-1:0]   words
);
    layout_t lay;
    assign lay = layout_of(mode_code);

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [SLOTS-1:0] w;
        if (L < WIDE_LANES) begin : g_wide
            always_comb begin
                w = lay.lane_en[L] ? wide_word(pix, 2'(L), lay.wide_base) : '0;
            end
        end else begin : g_narrow
            always_comb begin
                w = lay.lane_en[L] ? narrow_word(pix, lay.narrow_base[L-WIDE_LANES]) : '0;
            end
        end
        assign words[L] = w;
    end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SLOTS-1:0] word,
    output logic             ser
);
    logic [SLOTS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= word;
        end else begin
            sr <= {1'b0, sr[SLOTS-1:1]};
        end
    end

    assign ser = sr[0];
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int CW    = COLOR_W,
    localparam int SLOTS = NUM_SLOTS,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [CW-1:0]     red,
    input  logic [CW-1:0]     green,
    input  logic [CW-1:0]     blue,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              de,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk
);
    logic [MODE_W-1:0]            mode_q;
    logic [SW-1:0]                slot_idx;
    logic                         load;
    pixel_t                       pix;
    logic [LANES-1:0][SLOTS-1:0]  words;

    // packing select is frozen outside reset
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode;
        end
    end

    always_comb begin
        pix       = '0;
        pix.red   = COLOR_W'(red);
        pix.green = COLOR_W'(green);
        pix.blue  = COLOR_W'(blue);
        pix.hsync = hsync;
        pix.vsync = vsync;
        pix.de    = de;
    end

    lvds_slot_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .slot (slot_idx),
        .load (load)
    );

    lvds_slot_mapper #(.LANES(LANES), .SLOTS(SLOTS)) u_map (
        .mode_code (mode_q),
        .pix       (pix),
        .words     (words)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_data
        lvds_lane_shifter #(.SLOTS(SLOTS)) u_sh (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .word (words[L]),
            .ser  (lane_data[L])
        );
    end

    lvds_lane_shifter #(.SLOTS(SLOTS)) u_clk_sh (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .word (CLK_LANE_WORD),
        .ser  (lane_clk)
    );
endmodule

// File: rtl/lvds_pixel_serializer_sva.sv
module lvds_pixel_serializer_sva (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_q,
    input logic [2:0] slot,
    input logic [4:0] lane_data,
    input logic       lane_clk
);
    p_rst_quiet_r1: assert property (@(posedge clk)
        rst |=> (lane_data == 5'd0 && !lane_clk));

    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd6) |=> (slot == 3'd0));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot != 3'd6) |=> (slot == $past(slot) + 3'd1));

    p_clk_shape_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(lane_clk) |=> (!lane_clk ##1 !lane_clk ##1 lane_clk ##1 lane_clk
                             ##1 lane_clk ##1 lane_clk ##1 !lane_clk));

    p_clk_slot0_r2: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd0) |-> lane_clk);

    p_ctl3_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (slot == 3'd0) |-> (lane_data[4:3] == 2'b00));

    p_narrow_off_18_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'd0) |-> (lane_data[4:3] == 2'b00));

    p_lane4_off_24_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'd1 || mode_q == 3'd2) |-> !lane_data[4]);

    p_bad_code_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_q > 3'd4) |-> (lane_data == 5'd0));

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));
endmodule

bind lvds_pixel_serializer lvds_pixel_serializer_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .slot      (slot_idx),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
);

// File: tb/lvds_pixel_serializer_test.sv
module lvds_pixel_serializer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst;
    logic [2:0] mode;
    logic [9:0] red, green, blue;
    logic       hsync, vsync, de;
    logic [4:0] lane_data;
    logic       lane_clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    lvds_pixel_serializer uut (
        .clk(clk), .rst(rst), .mode(mode),
        .red(red), .green(green), .blue(blue),
        .hsync(hsync), .vsync(vsync), .de(de),
        .lane_data(lane_data), .lane_clk(lane_clk)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // expected lane word, bit s = slot s (concatenations list slot 6 first)
    function automatic logic [6:0] exp_word(int m, logic [9:0] r, logic [9:0] g,
                                            logic [9:0] b, logic hs, logic vs,
                                            logic en, int lane);
        logic [6:0] v0, v1, v2, v3, v4;
        v0 = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
        v1 = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
        v2 = {b[2], b[3], b[4], b[5], hs, vs, en};
        v3 = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
        v4 = {r[8], r[9], g[8], g[9], b[8], b[9], 1'b0};
        case (m)
            0: case (lane) 0: return v0; 1: return v1; 2: return v2; default: return 7'd0; endcase
            1: case (lane)
                0: return {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
                1: return {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
                2: return {b[4], b[5], b[6], b[7], hs, vs, en};
                3: return {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
                default: return 7'd0;
            endcase
            2: case (lane) 0: return v0; 1: return v1; 2: return v2; 3: return v3; default: return 7'd0; endcase
            3: case (lane)
                0: return {r[4], r[5], r[6], r[7], r[8], r[9], g[4]};
                1: return {g[5], g[6], g[7], g[8], g[9], b[4], b[5]};
                2: return {b[6], b[7], b[8], b[9], hs, vs, en};
                3: return {r[2], r[3], g[2], g[3], b[2], b[3], 1'b0};
                default: return {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
            endcase
            4: case (lane) 0: return v0; 1: return v1; 2: return v2; 3: return v3; default: return v4; endcase
            default: return 7'd0;
        endcase
    endfunction

    function automatic string mode_req(int m);
        case (m)
            0: return "R8";
            1: return "R5";
            2: return "R4";
            3: return "R7";
            4: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic do_reset(logic [2:0] m);
        @(negedge clk);
        rst  = 1'b1;
        mode = m;
        repeat (3) @(negedge clk);
        check(lane_data == 5'd0 && lane_clk == 1'b0, "R1",
              {26'd0, lane_clk, lane_data}, 32'd0);
        rst = 1'b0;
    endtask

    // one pixel period; called at a falling edge just before the loading edge
    task automatic xfer(int m, logic [9:0] r, logic [9:0] g, logic [9:0] b,
                        logic hs, logic vs, logic en, bit scramble, bit flip, string req);
        logic [6:0] got [5];
        logic [6:0] clk_got;
        red = r; green = g; blue = b; hsync = hs; vsync = vs; de = en;
        for (int s = 0; s < 7; s++) begin
            @(posedge clk);
            @(negedge clk);
            for (int l = 0; l < 5; l++) got[l][s] = lane_data[l];
            clk_got[s] = lane_clk;
            if (scramble && s == 2) begin
                red = 10'($urandom); green = 10'($urandom); blue = 10'($urandom);
                hsync = ~hs; vsync = ~vs; de = ~en;
            end
            if (flip && s == 3) mode = ~mode;
        end
        for (int l = 0; l < 5; l++) begin
            logic [6:0] want;
            want = exp_word(m, r, g, b, hs, vs, en, l);
            check(got[l] == want, req, {25'd0, got[l]}, {25'd0, want});
        end
        check(clk_got == 7'b1100011, "R2", {25'd0, clk_got}, 32'h63);
    endtask

    task automatic rand_xfer(int m, bit scramble, bit flip, string req);
        xfer(m, 10'($urandom), 10'($urandom), 10'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), scramble, flip, req);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h1d5e_a7c1);
        rst = 1'b1; mode = 3'd0;
        red = '0; green = '0; blue = '0; hsync = 0; vsync = 0; de = 0;
        for (int m = 0; m < 8; m++) begin
            if (m == 6) continue;
            do_reset(3'(m));
            // directed corners
            xfer(m, 10'h3ff, 10'h3ff, 10'h3ff, 1, 1, 1, 0, 0, mode_req(m));
            xfer(m, 10'h000, 10'h000, 10'h000, 0, 0, 0, 0, 0, mode_req(m));
            xfer(m, 10'h000, 10'h000, 10'h000, 1, 0, 0, 0, 0, "R9");
            xfer(m, 10'h000, 10'h000, 10'h000, 0, 1, 0, 0, 0, "R9");
            xfer(m, 10'h000, 10'h000, 10'h000, 0, 0, 1, 0, 0, "R9");
            xfer(m, 10'h2aa, 10'h155, 10'h0f0, 0, 1, 1, 0, 0, mode_req(m));
            xfer(m, 10'h3c0, 10'h3c0, 10'h3c0, 0, 0, 0, 0, 0, mode_req(m));
            for (int k = 0; k < 10; k++) begin
                xfer(m, 10'(1 << k), 10'(1 << ((k + 3) % 10)), 10'(1 << ((k + 7) % 10)),
                     0, 0, 0, 0, 0, mode_req(m));
            end
            for (int n = 0; n < 30; n++) begin
                if (n % 6 == 2)       rand_xfer(m, 1, 0, "R3");
                else if (n == 11)     rand_xfer(m, 0, 1, "R10");
                else                  rand_xfer(m, 0, 0, mode_req(m));
            end
            // mode was altered mid-run: packing must still be the latched one
            rand_xfer(m, 0, 0, "R10");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule